// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block sits behind the comparator bank of an 8-bit flash converter. The bank has 256 comparators. Each clock it receives their outputs as one digital vector. Comparator `i` reads 1 when the analog input is above its ladder tap, so a clean input looks like a run of ones from index 0 upward, followed by zeros. The block turns that vector into an 8-bit result word and an overrange flag. It also drives a data-ready level that changes once per new result, so a downstream capture register can clock on it.

The decode is split into four column decoders of 64 comparators each. Each column decoder finds the highest 1-to-0 step inside its own slice and latches a 6-bit local code and a column-active flag on the falling clock edge. A column combiner takes the highest active column, which gives the two top bits. The detector needs two ones under every zero it accepts as the step. Because of that, one stray comparator bit moves the result by at most one step. Three polarity controls are sampled with the vector:
- one flips the top result bit;
- one flips the lower seven result bits;
- one flips the data-ready level.

An overrange result overrides both result-bit controls.

Top module: `therm_bin_encoder`

## Requirements
- R1: With `therm_i[i]=1` for every `i<k` and 0 elsewhere (k from 0 to 255), and both result-bit controls low, `data_o` equals k as plain binary and `ovr_o` is 0. An all-zero vector gives 0.
- R2: A vector sampled on rising edge n sets the outputs on rising edge n+1. A new vector is accepted on every rising edge.
- R3: The two top result bits are the index (0 to 3) of the 64-bit column holding the step. Steps just below, on, and just above every column boundary (k = 63, 64, 65, 127, 128, 191, 192, 255) decode exactly.
- R4: A single comparator bit flipped from a clean code k moves the decoded value by at most 1. Positions 255 and k-2 are the exceptions. Flipping position k-2 makes the vector read as the clean code k-2 with a stray 1 above it, and the result is k-2.
- R5: When the vector has several 1-to-0 steps, each above a run of at least two ones, the result is the highest step.
- R6: `msb_inv_i` high flips `data_o[7]` only. `lsb_inv_i` high flips `data_o[6:0]` only. With only `msb_inv_i` high, the result is two's complement around mid-scale. With both high, every result bit is flipped. Both controls take effect with the vector sampled on the same edge.
- R7: When `therm_i[255]` is 1, `ovr_o` is 1 and `data_o` is all ones, whatever the result-bit controls are.
- R8: `rdy_o` changes level once for every new result. After reset, the first result drives it high when `rdy_inv_i` is low. `rdy_inv_i` high inverts the level for the result sampled with it.
- R9: A rising edge with `rst` high drives `data_o`, `ovr_o` and `rdy_o` to 0. The first result after `rst` falls appears on the second rising edge at which `rst` is low. Until then the outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock. Vector sampled on rise, column codes latched on fall |
| rst | input | 1 | Synchronous reset, active high |
| therm_i | input | 256 | Comparator outputs, bit i for ladder tap i |
| msb_inv_i | input | 1 | Flip the top result bit |
| lsb_inv_i | input | 1 | Flip the lower seven result bits |
| rdy_inv_i | input | 1 | Invert the data-ready level |
| data_o | output | 8 | Result word |
| ovr_o | output | 1 | Overrange flag |
| rdy_o | output | 1 | Data-ready level |

## Verification
Overrange forcing and the polarity flips can act on the same result. That case is checked two ways. Random stimulus draws the full-scale code together with random control settings. A directed pass walks all four combinations of the result-bit controls while the top comparator is set, and each such result must come out all ones. The data-ready polarity flip is exercised in the same stream, so the bench also judges the level against a toggle count kept separately from the result word. Stray-bit vectors are checked for a decoded value within one step of the injected clean code, after the expected flips have been undone.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Polarity controls sampled together with one comparator vector
  typedef struct packed {
    logic msb_flip;
    logic lsb_flip;
    logic rdy_flip;
  } tc_ctl_t;

endpackage

// File: rtl/tc_col_dec.sv
// One column decoder: finds the highest accepted step inside its slice and
// holds the local code plus an active flag in a falling-edge register.
module tc_col_dec #(
  parameter int COL_W = 64,
  localparam int LW = $clog2(COL_W)
) (
  input  logic             clk,
  input  logic             rst,
  // win[1:0] are the two comparators below the slice, win[COL_W+1:2] the slice
  input  logic [COL_W+1:0] win,
  output logic [LW-1:0]    code_q,
  output logic             act_q
);

  logic [COL_W-1:0] step;
  logic [LW-1:0]    code_c;
  logic             act_c;

  // Step at local position l: two ones directly below, zero at l
  always_comb begin
    for (int l = 0; l < COL_W; l++) begin
      step[l] = win[l] & win[l+1] & ~win[l+2];
    end
  end

  // Highest accepted step wins
  always_comb begin
    code_c = '0;
    act_c  = 1'b0;
    for (int l = 0; l < COL_W; l++) begin
      if (step[l]) begin
        code_c = LW'(l);
        act_c  = 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      code_q <= '0;
      act_q  <= 1'b0;
    end else begin
      code_q <= code_c;
      act_q  <= act_c;
    end
  end

endmodule

// File: rtl/tc_col_merge.sv
// Column combiner: highest active column supplies the top bits and its code.
module tc_col_merge #(
  parameter int COLS = 4,
  parameter int LW   = 6,
  localparam int MW  = $clog2(COLS)
) (
  input  logic [COLS-1:0][LW-1:0] codes,
  input  logic [COLS-1:0]         acts,
  output logic [MW+LW-1:0]        code
);

  always_comb begin
    code = '0;
    for (int c = 0; c < COLS; c++) begin
      if (acts[c]) begin
        code = {MW'(c), codes[c]};
      end
    end
  end

endmodule

// File: rtl/tc_out_stage.sv
// Output register: polarity flips, overrange forcing, data-ready toggle.
module tc_out_stage
  import tc_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [OUT_W-1:0] code,
  input  logic             ovr,
  input  tc_ctl_t          ctl,
  output logic [OUT_W-1:0] data_o,
  output logic             ovr_o,
  output logic             rdy_o
);

  logic             tgl;
  logic [OUT_W-1:0] flip_mask;

  assign flip_mask = {ctl.msb_flip, {(OUT_W-1){ctl.lsb_flip}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      ovr_o  <= 1'b0;
      rdy_o  <= 1'b0;
      tgl    <= 1'b0;
    end else if (vld) begin
      tgl    <= ~tgl;
      rdy_o  <= ~tgl ^ ctl.rdy_flip;
      ovr_o  <= ovr;
      data_o <= ovr ? '1 : (code ^ flip_mask);
    end
  end

endmodule

// File: rtl/therm_bin_encoder.sv
module therm_bin_encoder
  import tc_pkg::*;
#(
  parameter int COLS  = 4,
  parameter int COL_W = 64,
  localparam int N     = COLS * COL_W,
  localparam int LW    = $clog2(COL_W),
  localparam int MW    = $clog2(COLS),
  localparam int OUT_W = LW + MW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     therm_i,
  input  logic             msb_inv_i,
  input  logic             lsb_inv_i,
  input  logic             rdy_inv_i,
  output logic [OUT_W-1:0] data_o,
  output logic             ovr_o,
  output logic             rdy_o
);

  // Rising-edge capture stage
  logic [N-1:0] th_q;
  tc_ctl_t      ctl0;
  logic         v0;

  always_ff @(posedge clk) begin
    if (rst) begin
      th_q <= '0;
      ctl0 <= '0;
      v0   <= 1'b0;
    end else begin
      th_q <= therm_i;
      ctl0 <= '{msb_flip: msb_inv_i, lsb_flip: lsb_inv_i, rdy_flip: rdy_inv_i};
      v0   <= 1'b1;
    end
  end

  // Column decoders with falling-edge latches
  logic [COLS-1:0][LW-1:0] col_code;
  logic [COLS-1:0]         col_act;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [COL_W+1:0] win;
    if (c == 0) begin : g_bottom
      assign win = {th_q[COL_W-1:0], 2'b11};
    end else begin : g_upper
      assign win = th_q[c*COL_W+COL_W-1 -: COL_W+2];
    end
    tc_col_dec #(.COL_W(COL_W)) u_dec (
      .clk    (clk),
      .rst    (rst),
      .win    (win),
      .code_q (col_code[c]),
      .act_q  (col_act[c])
    );
  end

  // Side-band values travelling with the column latches
  logic    ovr1;
  tc_ctl_t ctl1;
  logic    v1;

  always_ff @(negedge clk) begin
    if (rst) begin
      ovr1 <= 1'b0;
      ctl1 <= '0;
      v1   <= 1'b0;
    end else begin
      ovr1 <= th_q[N-1];
      ctl1 <= ctl0;
      v1   <= v0;
    end
  end

  logic [OUT_W-1:0] merged;

  tc_col_merge #(.COLS(COLS), .LW(LW)) u_merge (
    .codes (col_code),
    .acts  (col_act),
    .code  (merged)
  );

  tc_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .vld    (v1),
    .code   (merged),
    .ovr    (ovr1),
    .ctl    (ctl1),
    .data_o (data_o),
    .ovr_o  (ovr_o),
    .rdy_o  (rdy_o)
  );

endmodule

// File: rtl/tc_enc_chk.sv
module tc_enc_chk #(
  parameter int N     = 256,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     therm_i,
  input logic             msb_inv_i,
  input logic             lsb_inv_i,
  input logic             rdy_inv_i,
  input logic [OUT_W-1:0] data_o,
  input logic             ovr_o,
  input logic             rdy_o
);

  // Consecutive rising edges with reset low, saturating at 3
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_o == '0 && !ovr_o && !rdy_o)); // R9

  AST_OVR_FORCED: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> (data_o == '1)); // R7

  AST_OVR_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |-> (ovr_o == $past(therm_i[N-1], 2))); // R2

  AST_ZERO_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && $past(therm_i, 2) == '0) |->
      (data_o == {$past(msb_inv_i, 2), {(OUT_W-1){$past(lsb_inv_i, 2)}}})); // R6

  AST_RDY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |->
      ((rdy_o ^ $past(rdy_inv_i, 2)) != ($past(rdy_o) ^ $past(rdy_inv_i, 3)))); // R8

endmodule

bind therm_bin_encoder tc_enc_chk #(.N(N), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .therm_i   (therm_i),
  .msb_inv_i (msb_inv_i),
  .lsb_inv_i (lsb_inv_i),
  .rdy_inv_i (rdy_inv_i),
  .data_o    (data_o),
  .ovr_o     (ovr_o),
  .rdy_o     (rdy_o)
);

// File: tb/sim_therm_bin_encoder.sv
`timescale 1ns/1ps
module sim_therm_bin_encoder;

  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] therm_i = '0;
  logic         msb_inv_i = 1'b0, lsb_inv_i = 1'b0, rdy_inv_i = 1'b0;
  logic [7:0]   data_o;
  logic         ovr_o, rdy_o;

  always #2 clk = ~clk; // 250 MHz

  therm_bin_encoder u0 (
    .clk(clk), .rst(rst), .therm_i(therm_i),
    .msb_inv_i(msb_inv_i), .lsb_inv_i(lsb_inv_i), .rdy_inv_i(rdy_inv_i),
    .data_o(data_o), .ovr_o(ovr_o), .rdy_o(rdy_o)
  );

  typedef struct {
    bit rst;
    bit tol;   // 1: result must lie within one step of k
    int k;     // expected code, 256 means overrange
    bit mi, li, ri;
  } ent_t;

  int    n_chk = 0, n_bad = 0;
  ent_t  d1, d2;
  string t1, t2;
  bit    tgl_b = 1'b0;
  bit    done = 1'b0;

  function automatic logic [N-1:0] clean_vec(int k);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) if (i < k) v[i] = 1'b1;
    return v;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Checks the outputs set by the latest rising edge
  task automatic check_now();
    int  mask, raw, ed;
    if (d1.rst) begin
      tgl_b = 1'b0;
      cmp("R9", {23'd0, ovr_o, rdy_o, data_o}, 0);
    end else if (d2.rst) begin
      cmp("R9", {23'd0, ovr_o, rdy_o, data_o}, 0);
    end else begin
      tgl_b = ~tgl_b;
      cmp("R8", int'(rdy_o), int'(tgl_b ^ d2.ri));
      mask = {24'd0, d2.mi, {7{d2.li}}};
      if (d2.k == 256) begin
        cmp("R7", int'(ovr_o), 1);
        cmp("R7", int'(data_o), 255);
      end else if (d2.tol) begin
        cmp(t2, int'(ovr_o), 0);
        raw = int'(data_o) ^ mask;
        ed  = raw - d2.k;
        n_chk++;
        if (ed > 1 || ed < -1) begin
          n_bad++;
          $display("FAIL %s actual=%0d expected=%0d+-1", t2, raw, d2.k);
        end
      end else begin
        cmp(t2, int'(ovr_o), 0);
        cmp(t2, int'(data_o), (d2.k & 255) ^ mask);
      end
    end
  endtask

  task automatic step(string tag, bit r, bit tol, int k, logic [N-1:0] v,
                      bit mi, bit li, bit ri);
    ent_t e;
    @(posedge clk);
    #1;
    check_now();
    rst = r; therm_i = v; msb_inv_i = mi; lsb_inv_i = li; rdy_inv_i = ri;
    e.rst = r; e.tol = tol; e.k = k; e.mi = mi; e.li = li; e.ri = ri;
    d2 = d1; t2 = t1;
    d1 = e;  t1 = tag;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    int k, j;
    void'($urandom(32'h5EED_0A17));
    d1 = '{rst: 1'b1, tol: 1'b0, k: 0, mi: 1'b0, li: 1'b0, ri: 1'b0};
    d2 = d1; t1 = "R9"; t2 = "R9";
    for (int i = 0; i < 4; i++) step("R9", 1, 0, 0, '0, 0, 0, 0);

    // R1: plain codes, including all-zero and a walk of values
    step("R1", 0, 0, 0, '0, 0, 0, 0);
    for (int i = 1; i < 256; i += 17) step("R1", 0, 0, i, clean_vec(i), 0, 0, 0);
    // R3: column boundaries
    foreach (v[i]) if (i == 0) begin end
    for (int b = 0; b < 8; b++) begin
      k = (b == 0) ? 63 : (b == 1) ? 64 : (b == 2) ? 65 : (b == 3) ? 127 :
          (b == 4) ? 128 : (b == 5) ? 191 : (b == 6) ? 192 : 255;
      step("R3", 0, 0, k, clean_vec(k), 0, 0, 0);
    end
    // R6: every flip combination on a few codes; R7 overrange under each
    for (int m = 0; m < 4; m++) begin
      step("R6", 0, 0, 0,   '0,             m[1], m[0], 0);
      step("R6", 0, 0, 128, clean_vec(128), m[1], m[0], 0);
      step("R6", 0, 0, 200, clean_vec(200), m[1], m[0], 0);
      step("R7", 0, 0, 256, '1,             m[1], m[0], m[0]);
    end
    // R5: two runs, upper run ends at 150
    v = clean_vec(40) | (clean_vec(150) & ~clean_vec(100));
    step("R5", 0, 0, 150, v, 0, 0, 0);
    v = clean_vec(3) | (clean_vec(70) & ~clean_vec(60)) | (clean_vec(230) & ~clean_vec(227));
    step("R5", 0, 0, 230, v, 1, 0, 1);
    // R4: flip two below the step reads as code k-2
    v = clean_vec(90); v[88] = 1'b0;
    step("R4", 0, 0, 88, v, 0, 0, 0);
    // R8: polarity changes on consecutive results
    for (int i = 0; i < 6; i++) step("R8", 0, 0, 10 * i, clean_vec(10 * i), 0, 0, i[0]);

    // R2: back-to-back random stream with stray bits
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        k = $urandom_range(4, 250);
        j = $urandom_range(0, 254);
        if (j == k - 2) j = k;
        v = clean_vec(k); v[j] = ~v[j];
        step("R4", 0, 1, k, v, 1'($urandom), 1'($urandom), 1'($urandom));
      end else begin
        k = $urandom_range(0, 256);
        step("R2", 0, 0, k, clean_vec(k), 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    // R9: reset in mid-stream, then resume
    for (int i = 0; i < 3; i++) step("R9", 1, 0, 0, '1, 1, 1, 1);
    for (int i = 0; i < 6; i++) step("R1", 0, 0, 33 * i, clean_vec(33 * i), 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, '0, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule